// File: doc/BRIEF.md
# Staircase Harmonic-Elimination Gate Sequencer

This block produces the switch pattern for one leg of a diode-clamped multilevel inverter that runs a stepped staircase waveform with twelve levels. A 16-bit phase accumulator sweeps one fundamental period. The top two phase bits pick the quadrant and the half-cycle. The phase is folded into the first quarter, mirrored in time in the second and fourth quarters, and then compared against eleven stored switching angles. The number of angles at or below the folded phase gives the present level, from 0 to 11.

The level selects a window of 22 adjacent conducting switches out of 44. A separate flag marks the negative half-cycle. The angle set comes from an internal table of six sets, one for each modulation index from 0.70 to 0.95 in steps of 0.05, chosen by a select input. A new select value is only taken up at a period boundary, so the block never uses part of one angle set and part of another. All outputs are registered. A one-cycle strobe marks every level change.

Top module: `stair_gate_seq`

## Requirements
- R1: While reset is high, and after it is released until enable is first raised, the outputs hold the level-0 state: gate bits 11 to 32 high and all others low, polarity 0, level 0, strobe 0. The phase stays at zero, so the first enabled cycle evaluates phase 0.
- R2: On each clock edge with enable high, the 16-bit phase advances by the increment input, modulo 65536. On an edge with enable low, the phase, gate vector, polarity and level keep their values and the strobe is 0.
- R3: The folded phase is built from the phase. In quadrants 0 and 2 (phase bit 14 = 0) it is phase bits 13:0. In quadrants 1 and 3 it is the bitwise inverse of phase bits 13:0. The level is the count of the eleven active angles that are less than or equal to the folded phase.
- R4: The polarity output equals phase bit 15, so it is 1 during the second half-cycle. The level in the second half repeats the level of the first half.
- R5: Gate bit j (switch j+1, j = 0 to 43) is high exactly when 11−L ≤ j ≤ 32−L for level L. Exactly 22 bits are high in every cycle.
- R6: Angle k (k = 1 to 11) of set s is min(16384, 1200 − 240·s + (k−1)·(1600 − 40·s)), in units of 1/16384 of a quarter period. Select values 0 to 5 pick sets 0 to 5 (index 0.70 to 0.95). Values 6 and 7 act as 5. An angle of 16384 is never reached, and an angle of 0 is always counted, so set 0 never exceeds level 10 and set 5 never drops below level 1.
- R7: Once the block has started, the active set changes only on the edge where the phase addition carries past 65535. Before the first enabled edge, the set follows the select input.
- R8: On an enabled edge the outputs take the values for the phase held before that edge. The strobe is 1 for that cycle exactly when the new level differs from the previous one.
- R9: A change of one level toggles exactly two gate bits: one switch turns on and one turns off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| phaseIncr | input | 16 | Phase step per enabled clock |
| idxSel | input | 3 | Modulation-index set select |
| gateOut | output | 44 | Conduction vector, bit j drives switch j+1 |
| negHalf | output | 1 | High during the negative half-cycle |
| levelOut | output | 4 | Present staircase level |
| levelStep | output | 1 | One-cycle strobe on a level change |

## Verification
The embedded assertions check the following on every cycle:
- the conduction window always holds 22 switches;
- the level never goes above 11;
- a single-level step moves exactly two gate bits;
- nothing moves while enable is low;
- the active set is held between period boundaries and stays in range.

The exact levels that the folded phase and the angle table give can only be shown by the bench scenarios, which replay the phase in a model. The same holds for the level ceiling of set 0 and the floor of set 5, the clamping of select values 6 and 7, and a select change made in mid-period that waits for the wrap.

// File: rtl/stair_gate_pkg.sv
package stair_gate_pkg;

  localparam int PHASE_W    = 16;
  localparam int ANGLE_W    = 14;
  localparam int NUM_ANGLES = 11;
  localparam int NUM_SETS   = 6;
  localparam int SEL_W      = 3;

  // angle-set generator constants (units of 1/2^ANGLE_W quarter period)
  localparam int BASE0    = 1200;
  localparam int BASE_DEC = 240;
  localparam int STEP0    = 1600;
  localparam int STEP_DEC = 40;

  typedef struct packed {
    logic advance;   // phase moves on this edge
    logic mirror;    // odd quadrant: time-mirrored fold
    logic negative;  // second half-cycle
  } seqStrobe_t;

  function automatic int angleOf(input int setNum, input int stepNum, input int quarter);
    int v;
    v = (BASE0 - BASE_DEC * setNum) + (stepNum - 1) * (STEP0 - STEP_DEC * setNum);
    if (v > quarter) v = quarter;
    if (v < 0) v = 0;
    return v;
  endfunction

endpackage

// File: rtl/stair_gate_ctrl.sv
module stair_gate_ctrl
  import stair_gate_pkg::*;
#(
  parameter int PHASE_BITS = PHASE_W,
  parameter int ANGLE_BITS = ANGLE_W,
  parameter int SETS       = NUM_SETS,
  parameter int SEL_BITS   = SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [PHASE_BITS-1:0] phaseIncr,
  input  logic [SEL_BITS-1:0]   idxSel,
  output seqStrobe_t            strobe,
  output logic [ANGLE_BITS-1:0] lowPhase,
  output logic [SEL_BITS-1:0]   setIdx
);

  localparam logic [SEL_BITS-1:0] LAST_SET = SEL_BITS'(SETS - 1);

  logic [PHASE_BITS-1:0] phaseQ;
  logic [PHASE_BITS:0]   sumFull;
  logic                  wrapNow;
  logic                  runningQ;
  logic [SEL_BITS-1:0]   setIdxQ;
  logic [SEL_BITS-1:0]   selClamped;

  assign sumFull    = {1'b0, phaseQ} + {1'b0, phaseIncr};
  assign wrapNow    = en & sumFull[PHASE_BITS];
  assign selClamped = (idxSel > LAST_SET) ? LAST_SET : idxSel;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ   <= '0;
      runningQ <= 1'b0;
      setIdxQ  <= '0;
    end else begin
      if (en) begin
        phaseQ   <= sumFull[PHASE_BITS-1:0];
        runningQ <= 1'b1;
      end
      if (!runningQ || wrapNow) setIdxQ <= selClamped;
    end
  end

  assign strobe.advance  = en;
  assign strobe.negative = phaseQ[PHASE_BITS-1];
  assign strobe.mirror   = phaseQ[PHASE_BITS-2];
  assign lowPhase        = phaseQ[ANGLE_BITS-1:0];
  assign setIdx          = setIdxQ;

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phaseQ));

  // R7
  set_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (runningQ && !wrapNow) |=> $stable(setIdxQ));

  // R6
  set_range_chk: assert property (@(posedge clk) disable iff (rst)
    setIdxQ <= LAST_SET);

endmodule

// File: rtl/stair_gate_dp.sv
module stair_gate_dp
  import stair_gate_pkg::*;
#(
  parameter int ANGLE_BITS = ANGLE_W,
  parameter int ANGLES     = NUM_ANGLES,
  parameter int SETS       = NUM_SETS,
  parameter int SEL_BITS   = SEL_W,
  localparam int NUM_SW    = 4 * ANGLES,
  localparam int LVL_W     = $clog2(ANGLES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  seqStrobe_t            strobe,
  input  logic [ANGLE_BITS-1:0] lowPhase,
  input  logic [SEL_BITS-1:0]   setIdx,
  output logic [NUM_SW-1:0]     gateOut,
  output logic                  negHalf,
  output logic [LVL_W-1:0]      levelOut,
  output logic                  levelStep
);

  localparam int AW      = ANGLE_BITS + 1;
  localparam int QUARTER = 1 << ANGLE_BITS;
  localparam int WIN     = 2 * ANGLES;
  localparam logic [NUM_SW-1:0] RESET_GATE = {{ANGLES{1'b0}}, {WIN{1'b1}}, {ANGLES{1'b0}}};

  logic [AW-1:0]         angleTbl [SETS][ANGLES];
  logic [ANGLE_BITS-1:0] folded;
  logic [LVL_W-1:0]      levelNext;
  logic [NUM_SW-1:0]     gateNext;

  logic [NUM_SW-1:0]     gateQ;
  logic                  negHalfQ;
  logic [LVL_W-1:0]      levelQ;
  logic                  stepQ;

  // angle table, one constant per set and step
  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar k = 0; k < ANGLES; k++) begin : g_ang
      localparam int AV = angleOf(s, k + 1, QUARTER);
      assign angleTbl[s][k] = AW'(AV);
    end
  end

  // quarter-wave fold: odd quadrants run backwards in time
  assign folded = strobe.mirror ? ~lowPhase : lowPhase;

  always_comb begin
    levelNext = '0;
    for (int k = 0; k < ANGLES; k++) begin
      if (angleTbl[setIdx][k] <= {1'b0, folded}) levelNext = levelNext + 1'b1;
    end
  end

  // sliding conduction window
  for (genvar j = 0; j < NUM_SW; j++) begin : g_win
    localparam int LO = ANGLES - j;
    localparam int HI = 3 * ANGLES - 1 - j;
    assign gateNext[j] = (int'(levelNext) >= LO) && (int'(levelNext) <= HI);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gateQ    <= RESET_GATE;
      negHalfQ <= 1'b0;
      levelQ   <= '0;
      stepQ    <= 1'b0;
    end else if (strobe.advance) begin
      gateQ    <= gateNext;
      negHalfQ <= strobe.negative;
      levelQ   <= levelNext;
      stepQ    <= (levelNext != levelQ);
    end else begin
      stepQ    <= 1'b0;
    end
  end

  assign gateOut   = gateQ;
  assign negHalf   = negHalfQ;
  assign levelOut  = levelQ;
  assign levelStep = stepQ;

  // R5
  window_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(gateQ) == WIN);

  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (rst)
    levelQ <= LVL_W'(ANGLES));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    (levelQ == $past(levelQ) + 1'b1) |-> ($countones(gateQ ^ $past(gateQ)) == 2));

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> ($stable(gateQ) && $stable(negHalfQ) && !stepQ));

endmodule

// File: rtl/stair_gate_seq.sv
module stair_gate_seq
  import stair_gate_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [PHASE_W-1:0]        phaseIncr,
  input  logic [SEL_W-1:0]          idxSel,
  output logic [4*NUM_ANGLES-1:0]   gateOut,
  output logic                      negHalf,
  output logic [$clog2(NUM_ANGLES+1)-1:0] levelOut,
  output logic                      levelStep
);

  seqStrobe_t          strobe;
  logic [ANGLE_W-1:0]  lowPhase;
  logic [SEL_W-1:0]    setIdx;

  stair_gate_ctrl #(
    .PHASE_BITS(PHASE_W), .ANGLE_BITS(ANGLE_W), .SETS(NUM_SETS), .SEL_BITS(SEL_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .en(en), .phaseIncr(phaseIncr), .idxSel(idxSel),
    .strobe(strobe), .lowPhase(lowPhase), .setIdx(setIdx)
  );

  stair_gate_dp #(
    .ANGLE_BITS(ANGLE_W), .ANGLES(NUM_ANGLES), .SETS(NUM_SETS), .SEL_BITS(SEL_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .lowPhase(lowPhase), .setIdx(setIdx),
    .gateOut(gateOut), .negHalf(negHalf), .levelOut(levelOut), .levelStep(levelStep)
  );

endmodule

// File: tb/stair_gate_seq_test.sv
`timescale 1ns/1ps
module stair_gate_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enB = 1'b0;
  logic [15:0] incrB = 16'd0;
  logic [2:0]  selB = 3'd0;
  logic [43:0] gateOut;
  logic        negHalf;
  logic [3:0]  levelOut;
  logic        levelStep;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  logic [15:0] mPhase;
  int          mSet;
  bit          mRunning;
  int          mLevel;
  logic [43:0] mGate;
  logic        mNeg;
  bit          lastWrap;

  always #2.5 clk = ~clk;

  stair_gate_seq uut (
    .clk(clk), .rst(rst), .en(enB), .phaseIncr(incrB), .idxSel(selB),
    .gateOut(gateOut), .negHalf(negHalf), .levelOut(levelOut), .levelStep(levelStep)
  );

  function automatic int benchAngle(input int s, input int k);
    int v;
    v = 1200 - 240 * s + (k - 1) * (1600 - 40 * s);
    return (v > 16384) ? 16384 : v;
  endfunction

  function automatic int benchLevel(input logic [15:0] ph, input int s);
    int f, n;
    f = int'(ph[13:0]);
    if (ph[14]) f = 16383 - f;
    n = 0;
    for (int k = 1; k <= 11; k++) if (benchAngle(s, k) <= f) n++;
    return n;
  endfunction

  function automatic logic [43:0] benchWindow(input int lv);
    logic [43:0] w;
    for (int j = 0; j < 44; j++) w[j] = (j >= 11 - lv) && (j <= 32 - lv);
    return w;
  endfunction

  function automatic int clampSel(input logic [2:0] s);
    return (s > 3'd5) ? 5 : int'(s);
  endfunction

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic applyReset(input logic [2:0] sel);
    rst = 1'b1; enB = 1'b0; selB = sel;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    mPhase = 16'd0; mSet = 0; mRunning = 0;
    mLevel = 0; mGate = benchWindow(0); mNeg = 1'b0;
  endtask

  // one clock edge against the model; inputs stable 1 ns after previous edge
  task automatic tick(input string tag);
    int eLvl; logic [43:0] eGate; logic eNeg; logic eStep; logic [16:0] s;
    if (enB) begin
      eLvl = benchLevel(mPhase, mSet);
      eGate = benchWindow(eLvl);
      eNeg = mPhase[15];
      eStep = (eLvl != mLevel);
    end else begin
      eLvl = mLevel; eGate = mGate; eNeg = mNeg; eStep = 1'b0;
    end
    s = {1'b0, mPhase} + {1'b0, incrB};
    lastWrap = enB && s[16];
    if (!mRunning || lastWrap) mSet = clampSel(selB);
    if (enB) begin mRunning = 1; mPhase = s[15:0]; end
    @(posedge clk); #1;
    check(gateOut == eGate && negHalf == eNeg && int'(levelOut) == eLvl && levelStep == eStep, tag,
          $sformatf("g=%h n=%0b l=%0d s=%0b", gateOut, negHalf, levelOut, levelStep),
          $sformatf("g=%h n=%0b l=%0d s=%0b", eGate, eNeg, eLvl, eStep));
    if (eLvl == mLevel + 1 || eLvl + 1 == mLevel)
      check($countones(gateOut ^ mGate) == 2, "R9 single step toggles two switches",
            $sformatf("%0d", $countones(gateOut ^ mGate)), "2");
    mLevel = eLvl; mGate = eGate; mNeg = eNeg;
  endtask

  task automatic testReset();
    applyReset(3'd2);
    check(gateOut == benchWindow(0), "R1 reset window", $sformatf("%h", gateOut),
          $sformatf("%h", benchWindow(0)));
    check(!negHalf && levelOut == 4'd0 && !levelStep, "R1 reset level/polarity/strobe",
          $sformatf("n=%0b l=%0d s=%0b", negHalf, levelOut, levelStep), "n=0 l=0 s=0");
    incrB = 16'd999;
    repeat (6) tick("R1 idle before enable");
    enB = 1'b1;
    tick("R1 first enabled edge uses phase 0");
    repeat (30) tick("R3/R8 after start");
  endtask

  task automatic testHold();
    applyReset(3'd3);
    incrB = 16'd1531; enB = 1'b1;
    repeat (25) tick("R2 running");
    enB = 1'b0;
    repeat (10) tick("R2 frozen while enable low");
    enB = 1'b1;
    repeat (25) tick("R2 resumed");
  endtask

  task automatic testSweep0();
    int maxL = 0;
    applyReset(3'd0);
    incrB = 16'd173; enB = 1'b1;
    for (int i = 0; i < 800; i++) begin
      tick("R3/R4/R5/R8 set 0 sweep");
      if (mLevel > maxL) maxL = mLevel;
    end
    check(maxL == 10, "R6 set 0 ceiling (pi/2 angle never reached)",
          $sformatf("%0d", maxL), "10");
  endtask

  task automatic testSet5(input logic [2:0] sel, input logic [15:0] inc, input string tag);
    int minL = 99; int maxL = 0;
    applyReset(sel);
    incrB = inc; enB = 1'b1;
    tick(tag);
    for (int i = 0; i < 700; i++) begin
      tick(tag);
      if (mLevel < minL) minL = mLevel;
      if (mLevel > maxL) maxL = mLevel;
    end
    check(minL == 1, "R6 zero angle always counted", $sformatf("%0d", minL), "1");
    check(maxL == 11, "R6 full level reached", $sformatf("%0d", maxL), "11");
  endtask

  task automatic testSwitch();
    int minBefore = 99; int minAfter = 99; bit wrapped = 0;
    applyReset(3'd5);
    incrB = 16'd300; enB = 1'b1;
    repeat (100) tick("R7 before change");
    selB = 3'd0;
    for (int i = 0; i < 300; i++) begin
      bit wasWrapped;
      wasWrapped = wrapped;
      tick("R7 select change mid-period");
      if (!wasWrapped) begin
        if (mLevel < minBefore) minBefore = mLevel;
      end else if (mLevel < minAfter) minAfter = mLevel;
      if (lastWrap) wrapped = 1;
    end
    check(minBefore >= 1, "R7 old set kept until wrap", $sformatf("%0d", minBefore), ">=1");
    check(minAfter == 0, "R7 new set after wrap", $sformatf("%0d", minAfter), "0");
  endtask

  task automatic testCoarse();
    applyReset(3'd1);
    incrB = 16'd4093; enB = 1'b1;
    repeat (120) tick("R8 coarse step level jumps");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testHold();
    testSweep0();
    testSet5(3'd5, 16'd97, "R3/R5 set 5 sweep");
    testSet5(3'd7, 16'd97, "R6 select 7 acts as 5");
    testSwitch();
    testCoarse();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule